// File: doc/BRIEF.md
# Streaming Maximum Finder (Decode, OR-Reduce, Highest-Select)

This block takes one wide word that packs many small unsigned values and returns the largest of them. It does not compare values in pairs. Each value is turned into a one-hot vector, one bit per possible value. All of those vectors are ORed bit by bit into a single presence vector, which records which values occur anywhere in the word. A highest-first arbiter keeps only the top set bit of the presence vector, and an encoder turns that bit back into a binary number. The whole path is logic and needs no compare-and-select stages.

The word enters on a valid/ready stream and the result leaves on a second valid/ready stream through a single output register. A word is taken on any cycle where `in_valid` and `in_ready` are both high. Its result appears on `out_max` on the next cycle with `out_valid` set. While `out_valid` is high and `out_ready` is low, the result is held and `in_ready` stays low, so back-pressure reaches the producer in the same cycle. When the consumer takes the result, a new word can be accepted in that same cycle, so the block can run at one word per clock. The flag `out_any` reports that at least one presence bit was set. Every value in the word is always present, so this flag is high with every result.

Top module: `maxfind_stream`

## Requirements
- R1: For an accepted word, `out_max` equals the largest of the N_IN values in it. Value k is the unsigned field `in_data[VAL_W*k + VAL_W-1 : VAL_W*k]`.
- R2: A word whose values are all zero gives `out_max` = 0.
- R3: Repeated values need no special handling. A word with every value at 15, or with several positions sharing the largest value, reports that value.
- R4: A word with a single nonzero value reports that value whether it sits at position 0 or at position N_IN-1.
- R5: `out_any` is 1 with every result that `out_valid` presents.
- R6: `in_ready` is high exactly when the output register is empty or `out_ready` is high. A word accepted at a clock edge shows up with `out_valid` high after that same edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_max` and `out_any` hold their values, and `in_data` is not taken.
- R8: While `rst_n` is low, and just after it rises, `out_valid` is low.
- R9: When a result is taken and no new word is offered, `out_valid` falls after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block can take the input word |
| in_data | input | N_IN*VAL_W | Packed values; value k is in field k |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_max | output | VAL_W | Largest value of the accepted word |
| out_any | output | 1 | At least one presence bit was set |

## Verification
The bench builds the block with the default parameters: 256 values of 4 bits each, and a radix-4 OR tree, which gives a four-level reduction. At this size every presence bit is the end of a full-depth tree. Test words can place the only nonzero value at either end of the 1024-bit bus. Random words are drawn with a range cap that steps from 0 to 15, so each of the 16 arbiter positions is the winner at some point, rather than only the top value that unrestricted random data almost always contains.

// File: rtl/maxfind_pkg.sv
package maxfind_pkg;
  // Default geometry of the finder.
  localparam int unsigned DEF_N_IN  = 256;
  localparam int unsigned DEF_VAL_W = 4;
  localparam int unsigned DEF_RADIX = 4;

  // Number of RADIX-wide OR levels needed to fold n vectors to one.
  function automatic int unsigned tree_levels(input int unsigned n, input int unsigned radix);
    int unsigned cnt;
    int unsigned lvl;
    cnt = n;
    lvl = 0;
    while (cnt > 1) begin
      cnt = (cnt + radix - 1) / radix;
      lvl = lvl + 1;
    end
    return lvl;
  endfunction
endpackage

// File: rtl/mf_onehot_decode.sv
// Binary value to one-hot vector: bit i is set when the value equals i.
module mf_onehot_decode #(
  parameter int unsigned VAL_W = 4,
  localparam int unsigned OH_W = 1 << VAL_W
) (
  input  logic [VAL_W-1:0] val_i,
  output logic [OH_W-1:0]  onehot_o
);
  for (genvar i = 0; i < OH_W; i++) begin : g_bit
    assign onehot_o[i] = (val_i == VAL_W'(i));
  end
endmodule

// File: rtl/mf_or_tree.sv
// Bitwise OR of N_IN vectors of width W, folded RADIX at a time per level.
// The module calls itself on the group results until one vector is left.
module mf_or_tree #(
  parameter int unsigned N_IN  = 256,
  parameter int unsigned W     = 16,
  parameter int unsigned RADIX = 4
) (
  input  logic [N_IN-1:0][W-1:0] vecs_i,
  output logic [W-1:0]           red_o
);
  if (N_IN <= 1) begin : g_leaf
    assign red_o = vecs_i[0];
  end else begin : g_level
    localparam int unsigned GROUPS = (N_IN + RADIX - 1) / RADIX;
    logic [GROUPS-1:0][W-1:0] grp;

    always_comb begin
      grp = '0;
      for (int g = 0; g < GROUPS; g++) begin
        for (int j = 0; j < RADIX; j++) begin
          if (g * RADIX + j < N_IN) begin
            grp[g] = grp[g] | vecs_i[g * RADIX + j];
          end
        end
      end
    end

    mf_or_tree #(
      .N_IN (GROUPS),
      .W    (W),
      .RADIX(RADIX)
    ) u_next (
      .vecs_i(grp),
      .red_o (red_o)
    );
  end
endmodule

// File: rtl/mf_high_arbiter.sv
// Keeps only the highest-index set bit of req_i (bit-slice chain from the top).
module mf_high_arbiter #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] grant_o
);
  // none_above[i]: no request at any index above i.
  logic [W-1:0] none_above;

  assign none_above[W-1] = 1'b1;
  for (genvar i = W - 2; i >= 0; i--) begin : g_chain
    assign none_above[i] = none_above[i+1] & ~req_i[i+1];
  end

  assign grant_o = req_i & none_above;
endmodule

// File: rtl/mf_onehot_encode.sv
// One-hot to binary: each output bit is the OR of the inputs whose index has it set.
module mf_onehot_encode #(
  parameter int unsigned VAL_W = 4,
  localparam int unsigned OH_W = 1 << VAL_W
) (
  input  logic [OH_W-1:0]  onehot_i,
  output logic [VAL_W-1:0] bin_o
);
  always_comb begin
    bin_o = '0;
    for (int i = 0; i < OH_W; i++) begin
      if (onehot_i[i]) begin
        bin_o = bin_o | VAL_W'(i);
      end
    end
  end
endmodule

// File: rtl/maxfind_stream.sv
module maxfind_stream
  import maxfind_pkg::*;
#(
  parameter int unsigned N_IN  = DEF_N_IN,
  parameter int unsigned VAL_W = DEF_VAL_W,
  parameter int unsigned RADIX = DEF_RADIX,
  localparam int unsigned DATA_W = N_IN * VAL_W,
  localparam int unsigned OH_W   = 1 << VAL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VAL_W-1:0]  out_max,
  output logic              out_any
);
  logic [N_IN-1:0][OH_W-1:0] dec_vec;
  logic [OH_W-1:0]           presence;
  logic [OH_W-1:0]           top_onehot;
  logic [VAL_W-1:0]          max_bin;
  logic                      accept;

  // One decoder per packed value.
  for (genvar k = 0; k < N_IN; k++) begin : g_dec
    mf_onehot_decode #(.VAL_W(VAL_W)) u_dec (
      .val_i   (in_data[k*VAL_W +: VAL_W]),
      .onehot_o(dec_vec[k])
    );
  end

  mf_or_tree #(
    .N_IN (N_IN),
    .W    (OH_W),
    .RADIX(RADIX)
  ) u_or (
    .vecs_i(dec_vec),
    .red_o (presence)
  );

  mf_high_arbiter #(.W(OH_W)) u_arb (
    .req_i  (presence),
    .grant_o(top_onehot)
  );

  mf_onehot_encode #(.VAL_W(VAL_W)) u_enc (
    .onehot_i(top_onehot),
    .bin_o   (max_bin)
  );

  // Single output register with pass-through ready.
  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_max   <= '0;
      out_any   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (accept) begin
        out_max <= max_bin;
        out_any <= |presence;
      end
    end
  end
endmodule

// File: rtl/maxfind_stream_chk.sv
module maxfind_stream_chk #(
  parameter int unsigned N_IN  = 256,
  parameter int unsigned VAL_W = 4,
  localparam int unsigned DATA_W = N_IN * VAL_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [VAL_W-1:0]  out_max,
  input logic              out_any
);
  logic [VAL_W-1:0] chk_exp;
  logic [VAL_W-1:0] loop_max;

  // Independent loop-based maximum of the offered word.
  always_comb begin
    loop_max = '0;
    for (int k = 0; k < N_IN; k++) begin
      if (in_data[k*VAL_W +: VAL_W] > loop_max) loop_max = in_data[k*VAL_W +: VAL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_exp <= '0;
    else if (in_valid && in_ready) chk_exp <= loop_max;
  end

  assert_max_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_max == chk_exp);

  assert_found_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_any);

  assert_accept_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_max) && $stable(out_any)));

  assert_reset_R8: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

bind maxfind_stream maxfind_stream_chk #(.N_IN(N_IN), .VAL_W(VAL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_max  (out_max),
  .out_any  (out_any)
);

// File: tb/maxfind_stream_tb.sv
`timescale 1ns/1ps
module maxfind_stream_tb;
  localparam int N_IN  = 256;
  localparam int VAL_W = 4;
  localparam int DW    = N_IN * VAL_W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic          out_valid;
  logic [VAL_W-1:0] out_max;
  logic          out_any;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit exp_valid = 1'b0;
  int exp_max = 0;

  always #2 clk = ~clk;

  maxfind_stream #(.N_IN(N_IN), .VAL_W(VAL_W), .RADIX(4)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_max(out_max), .out_any(out_any)
  );

  function automatic int ref_max(input logic [DW-1:0] d);
    int m = 0;
    for (int k = 0; k < N_IN; k++) begin
      if (int'(d[k*VAL_W +: VAL_W]) > m) m = int'(d[k*VAL_W +: VAL_W]);
    end
    return m;
  endfunction

  function automatic logic [DW-1:0] rand_vec(input int lim);
    logic [DW-1:0] d = '0;
    for (int k = 0; k < N_IN; k++) d[k*VAL_W +: VAL_W] = VAL_W'($urandom_range(lim, 0));
    return d;
  endfunction

  function automatic logic [DW-1:0] single_at(input int pos, input int val);
    logic [DW-1:0] d = '0;
    d[pos*VAL_W +: VAL_W] = VAL_W'(val);
    return d;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Drive one cycle, advance the model at the edge, compare after it.
  task automatic step(input bit v, input logic [DW-1:0] d, input bit r, input string tag);
    in_valid  = v;
    in_data   = d;
    out_ready = r;
    @(posedge clk);
    if (!exp_valid || r) begin
      exp_valid = v;
      if (v) exp_max = ref_max(d);
    end
    @(negedge clk);
    chk(tag, "out_valid", int'(out_valid), int'(exp_valid));
    chk("R6", "in_ready", int'(in_ready), int'(!exp_valid || out_ready));
    if (exp_valid) begin
      chk(tag, "out_max", int'(out_max), exp_max);
      chk("R5", "out_any", int'(out_any), 1);
    end
  endtask

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    chk("R8", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "out_valid after reset", int'(out_valid), 0);

    step(1'b1, '0, 1'b1, "R2");
    step(1'b1, {DW{1'b1}}, 1'b1, "R3");
    step(1'b1, single_at(0, 9), 1'b1, "R4");
    step(1'b1, single_at(N_IN - 1, 7), 1'b1, "R4");
    step(1'b1, single_at(0, 1), 1'b1, "R4");
    step(1'b1, single_at(N_IN - 1, 15), 1'b1, "R4");
    d = rand_vec(11);
    d[3*VAL_W +: VAL_W] = 4'd12;
    d[200*VAL_W +: VAL_W] = 4'd12;
    step(1'b1, d, 1'b1, "R3");
    step(1'b0, '0, 1'b1, "R9");

    // Random words with a rising cap so every value wins somewhere (R1).
    for (int lim = 0; lim < 16; lim++) begin
      for (int n = 0; n < 3; n++) step(1'b1, rand_vec(lim), 1'b1, "R1");
    end

    // Back-pressure: result held, new word refused (R7).
    step(1'b1, rand_vec(5), 1'b1, "R7");
    step(1'b1, rand_vec(15), 1'b0, "R7");
    step(1'b1, single_at(10, 14), 1'b0, "R7");
    step(1'b0, '0, 1'b1, "R9");
    step(1'b0, '0, 1'b1, "R9");

    // Mixed valid and ready patterns (R6).
    for (int n = 0; n < 200; n++) begin
      step(1'($urandom_range(1, 0)), rand_vec($urandom_range(15, 0)),
           1'($urandom_range(1, 0)), "R6");
    end
    step(1'b0, '0, 1'b1, "R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 50000);
    if (!done) begin
      n_bad++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule